// File: doc/BRIEF.md
# Interrupt Stacking and Return Sequencer

This block is the part of a small 8/16-bit processor core that moves the working registers between the register file and a byte-addressed stack whenever an interrupt is taken or left. When the interrupt arbiter raises a qualified request, the sequencer first sets the interrupt mask, then writes the return address, Y, X, the B/A pair and the condition code byte below the current stack pointer. It then loads the program counter and the stack pointer and asks the fetch unit to refill the instruction queue at the vector address.

On a return-from-interrupt command it reads the same frame back into the registers and clears the mask. One cycle later it checks whether another request is already pending. If none is pending, it refills the queue at the restored return address. If one is pending, it does not write the frame again. It moves the stack pointer back over the frame it just read, which is still valid in memory, and refills the queue at the new vector. This takes three cycles more than the plain return, and the memory-write phase of a full entry is skipped.

The stack port is byte addressed with two byte lanes. A wide access moves a 16-bit value high byte first, at the lower address. A narrow access uses only the upper lane. Read data returns one cycle after the request.

Top module: `isr_frame_seq`

## Requirements
- R1: After reset the block is idle: busy, mem_req, qfill_req, irq_ack and every register write enable are low.
- R2: When a request is accepted in an idle cycle, the first busy cycle writes the condition code byte with the mask bit (bit 4) set, and it makes no memory access in that cycle.
- R3: Entry stores a 9-byte frame below the stack pointer value sampled at acceptance (SP0). The frame is:
  - condition code byte as it was before masking at SP0-9;
  - B at SP0-8 and A at SP0-7;
  - X high and low bytes at SP0-6 and SP0-5;
  - Y high and low bytes at SP0-4 and SP0-3;
  - the return address (pc_in at acceptance) high and low bytes at SP0-2 and SP0-1.
  The stack pointer itself is never written to memory. A wide access carries the byte for the lower address in mem_wdata[15:8].
- R4: Entry lasts 7 busy cycles. Its last cycle pulses irq_ack once, writes SP0-9 to the stack pointer, writes irq_vec to the program counter, and requests a queue refill at irq_vec.
- R5: On a return command, the first busy cycle issues a narrow read at the stack pointer. By the end of the return, B, A, X and Y hold the frame contents. The condition code byte holds the frame value with bit 4 cleared, or with bit 4 set if R7 applies.
- R6: A return with no request pending in its 7th busy cycle lasts 8 busy cycles. It writes SP0+9 to the stack pointer and the return address to the program counter, requests a refill at the return address, and gives no irq_ack.
- R7: A return with a request pending in its 7th busy cycle lasts 11 busy cycles and pulses irq_ack exactly once. It leaves the stack pointer at SP0, sets the program counter to irq_vec, sets the mask bit, and requests a refill at irq_vec.
- R8: A request that is high only in busy cycles other than the 7th cycle of a return is ignored. The sequence keeps its normal length, no irq_ack is given, and no new sequence starts.
- R9: When a return command and a request are both high in the same idle cycle, the return is started.
- R10: Memory accesses and irq_ack occur only while busy, and a queue refill request is always the last busy cycle of a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Qualified interrupt request from the arbiter |
| irq_vec | input | 16 | Service routine start address for the request |
| irq_ack | output | 1 | Request taken, one-cycle pulse |
| rti_cmd | input | 1 | Return-from-interrupt command |
| busy | output | 1 | A sequence is in progress |
| ccr_in | input | 8 | Current condition code byte |
| a_in | input | 8 | Current A |
| b_in | input | 8 | Current B |
| x_in | input | 16 | Current X |
| y_in | input | 16 | Current Y |
| pc_in | input | 16 | Return address for entry |
| sp_in | input | 16 | Current stack pointer |
| ccr_we | output | 1 | Condition code write enable |
| ccr_wd | output | 8 | Condition code write data |
| ab_we | output | 1 | A and B write enable |
| a_wd | output | 8 | A write data |
| b_wd | output | 8 | B write data |
| x_we | output | 1 | X write enable |
| x_wd | output | 16 | X write data |
| y_we | output | 1 | Y write enable |
| y_wd | output | 16 | Y write data |
| pc_we | output | 1 | Program counter write enable |
| pc_wd | output | 16 | Program counter write data |
| sp_we | output | 1 | Stack pointer write enable |
| sp_wd | output | 16 | Stack pointer write data |
| mem_req | output | 1 | Stack memory access |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | Two-byte access (else upper lane only) |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data, [15:8] to mem_addr |
| mem_rdata | input | 16 | Read data, one cycle after the request |
| qfill_req | output | 1 | Refill the instruction queue (three words) |
| qfill_addr | output | 16 | Refill start address |

## Verification
The interesting collision is between a finishing return and a new request. The pending check in the 7th busy cycle of a return can meet a request that was raised in that same cycle, one cycle earlier, or one cycle later. A return command can also meet a request in a single idle cycle. The bench provokes these by raising and dropping irq_req at chosen busy-cycle numbers, both directed (the edges 6, 7 and 8 and the shared idle cycle) and at random positions. For each case it judges the outcome from the busy length (8 or 11), the number of acknowledges, the refill address, and the final stack pointer, program counter and mask bit.

// File: rtl/isr_seq_pkg.sv
package isr_seq_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_EMASK,
    ST_PUSH_RA,
    ST_PUSH_Y,
    ST_PUSH_X,
    ST_PUSH_BA,
    ST_PUSH_CCR,
    ST_EVEC,
    ST_POP_CCR,
    ST_POP_BA,
    ST_POP_X,
    ST_POP_Y,
    ST_POP_RA,
    ST_UNMASK,
    ST_DECIDE,
    ST_REFILL,
    ST_SVEC,
    ST_SSP,
    ST_SPC,
    ST_SFILL
  } seq_state_e;

endpackage

// File: rtl/isr_seq_ctrl.sv
module isr_seq_ctrl
  import isr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_req,
  input  logic       rti_cmd,
  output seq_state_e state,
  output logic       accept
);

  seq_state_e state_q, state_d;

  assign state  = state_q;
  assign accept = (state_q == ST_IDLE) && (rti_cmd || irq_req);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rti_cmd)      state_d = ST_POP_CCR;
        else if (irq_req) state_d = ST_EMASK;
      end
      ST_EMASK:    state_d = ST_PUSH_RA;
      ST_PUSH_RA:  state_d = ST_PUSH_Y;
      ST_PUSH_Y:   state_d = ST_PUSH_X;
      ST_PUSH_X:   state_d = ST_PUSH_BA;
      ST_PUSH_BA:  state_d = ST_PUSH_CCR;
      ST_PUSH_CCR: state_d = ST_EVEC;
      ST_EVEC:     state_d = ST_IDLE;
      ST_POP_CCR:  state_d = ST_POP_BA;
      ST_POP_BA:   state_d = ST_POP_X;
      ST_POP_X:    state_d = ST_POP_Y;
      ST_POP_Y:    state_d = ST_POP_RA;
      ST_POP_RA:   state_d = ST_UNMASK;
      ST_UNMASK:   state_d = ST_DECIDE;
      ST_DECIDE:   state_d = irq_req ? ST_SVEC : ST_REFILL;
      ST_REFILL:   state_d = ST_IDLE;
      ST_SVEC:     state_d = ST_SSP;
      ST_SSP:      state_d = ST_SPC;
      ST_SPC:      state_d = ST_SFILL;
      ST_SFILL:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/isr_seq_hold.sv
module isr_seq_hold
  import isr_seq_pkg::*;
#(
  parameter int DW = 8,
  localparam int WW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state,
  input  logic          accept,
  input  logic [DW-1:0] ccr_in,
  input  logic [WW-1:0] pc_in,
  input  logic [WW-1:0] sp_in,
  input  logic [WW-1:0] irq_vec,
  input  logic [WW-1:0] mem_rdata,
  output logic [DW-1:0] ccr_q,
  output logic [WW-1:0] ra_q,
  output logic [WW-1:0] sp_q,
  output logic [WW-1:0] vec_q
);

  logic          ccr_en, ra_en, sp_en, vec_en;
  logic [DW-1:0] ccr_d;
  logic [WW-1:0] ra_d;

  always_comb begin
    ccr_en = accept || (state == ST_POP_BA);
    ccr_d  = accept ? ccr_in : mem_rdata[WW-1:DW];
    ra_en  = accept || (state == ST_UNMASK);
    ra_d   = accept ? pc_in : mem_rdata;
    sp_en  = accept;
    vec_en = (state == ST_SVEC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q <= '0;
      ra_q  <= '0;
      sp_q  <= '0;
      vec_q <= '0;
    end else begin
      if (ccr_en) ccr_q <= ccr_d;
      if (ra_en)  ra_q  <= ra_d;
      if (sp_en)  sp_q  <= sp_in;
      if (vec_en) vec_q <= irq_vec;
    end
  end

endmodule

// File: rtl/isr_seq_agen.sv
module isr_seq_agen
  import isr_seq_pkg::*;
#(
  parameter int DW = 8,
  localparam int WW = 2 * DW
) (
  input  seq_state_e    state,
  input  logic [WW-1:0] sp_q,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [WW-1:0] mem_addr
);

  // frame layout relative to the final (lowest) stack pointer
  localparam int OFS_CCR   = 0;
  localparam int OFS_BA    = OFS_CCR + 1;
  localparam int OFS_X     = OFS_BA + 2;
  localparam int OFS_Y     = OFS_X + 2;
  localparam int OFS_RA    = OFS_Y + 2;
  localparam int FRAME_LEN = OFS_RA + 2;

  logic [WW-1:0] frame_base;
  logic [WW-1:0] ofs;

  always_comb begin
    mem_req  = 1'b1;
    mem_we   = 1'b0;
    mem_wide = 1'b1;
    ofs      = '0;
    // push states address below sp_q, pop states at or above it
    frame_base = sp_q;
    unique case (state)
      ST_PUSH_RA:  begin mem_we = 1'b1; ofs = WW'(OFS_RA);  end
      ST_PUSH_Y:   begin mem_we = 1'b1; ofs = WW'(OFS_Y);   end
      ST_PUSH_X:   begin mem_we = 1'b1; ofs = WW'(OFS_X);   end
      ST_PUSH_BA:  begin mem_we = 1'b1; ofs = WW'(OFS_BA);  end
      ST_PUSH_CCR: begin mem_we = 1'b1; ofs = WW'(OFS_CCR); mem_wide = 1'b0; end
      ST_POP_CCR:  begin ofs = WW'(OFS_CCR); mem_wide = 1'b0; end
      ST_POP_BA:   ofs = WW'(OFS_BA);
      ST_POP_X:    ofs = WW'(OFS_X);
      ST_POP_Y:    ofs = WW'(OFS_Y);
      ST_POP_RA:   ofs = WW'(OFS_RA);
      default: begin
        mem_req  = 1'b0;
        mem_wide = 1'b0;
      end
    endcase
    if (mem_we) frame_base = sp_q - WW'(FRAME_LEN);
    mem_addr = frame_base + ofs;
  end

endmodule

// File: rtl/isr_frame_seq.sv
module isr_frame_seq
  import isr_seq_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IBIT = 4,
  localparam int WW  = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic [WW-1:0] irq_vec,
  output logic          irq_ack,
  input  logic          rti_cmd,
  output logic          busy,
  input  logic [DW-1:0] ccr_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [WW-1:0] x_in,
  input  logic [WW-1:0] y_in,
  input  logic [WW-1:0] pc_in,
  input  logic [WW-1:0] sp_in,
  output logic          ccr_we,
  output logic [DW-1:0] ccr_wd,
  output logic          ab_we,
  output logic [DW-1:0] a_wd,
  output logic [DW-1:0] b_wd,
  output logic          x_we,
  output logic [WW-1:0] x_wd,
  output logic          y_we,
  output logic [WW-1:0] y_wd,
  output logic          pc_we,
  output logic [WW-1:0] pc_wd,
  output logic          sp_we,
  output logic [WW-1:0] sp_wd,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [WW-1:0] mem_addr,
  output logic [WW-1:0] mem_wdata,
  input  logic [WW-1:0] mem_rdata,
  output logic          qfill_req,
  output logic [WW-1:0] qfill_addr
);

  localparam logic [WW-1:0] FRAME_LEN = WW'(9);
  localparam logic [DW-1:0] IMASK     = DW'(1) << IBIT;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  seq_state_e    state;
  logic          accept;
  logic [DW-1:0] ccr_q;
  logic [WW-1:0] ra_q, sp_q, vec_q;

  isr_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sn),
    .irq_req (irq_req),
    .rti_cmd (rti_cmd),
    .state   (state),
    .accept  (accept)
  );

  isr_seq_hold #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_sn),
    .state     (state),
    .accept    (accept),
    .ccr_in    (ccr_in),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .irq_vec   (irq_vec),
    .mem_rdata (mem_rdata),
    .ccr_q     (ccr_q),
    .ra_q      (ra_q),
    .sp_q      (sp_q),
    .vec_q     (vec_q)
  );

  isr_seq_agen #(.DW(DW)) u_agen (
    .state    (state),
    .sp_q     (sp_q),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_wide (mem_wide),
    .mem_addr (mem_addr)
  );

  always_comb begin
    busy       = (state != ST_IDLE);
    irq_ack    = (state == ST_EVEC) || (state == ST_SVEC);
    ccr_we     = 1'b0;
    ccr_wd     = ccr_q | IMASK;
    ab_we      = (state == ST_POP_X);
    b_wd       = mem_rdata[WW-1:DW];
    a_wd       = mem_rdata[DW-1:0];
    x_we       = (state == ST_POP_Y);
    x_wd       = mem_rdata;
    y_we       = (state == ST_POP_RA);
    y_wd       = mem_rdata;
    pc_we      = 1'b0;
    pc_wd      = mem_rdata;
    sp_we      = 1'b0;
    sp_wd      = sp_q;
    qfill_req  = 1'b0;
    qfill_addr = ra_q;
    mem_wdata  = '0;
    unique case (state)
      ST_EMASK:    ccr_we = 1'b1;
      ST_PUSH_RA:  mem_wdata = ra_q;
      ST_PUSH_Y:   mem_wdata = y_in;
      ST_PUSH_X:   mem_wdata = x_in;
      ST_PUSH_BA:  mem_wdata = {b_in, a_in};
      ST_PUSH_CCR: mem_wdata = {ccr_q, {DW{1'b0}}};
      ST_EVEC: begin
        pc_we      = 1'b1;
        pc_wd      = irq_vec;
        sp_we      = 1'b1;
        sp_wd      = sp_q - FRAME_LEN;
        qfill_req  = 1'b1;
        qfill_addr = irq_vec;
      end
      ST_POP_BA: begin
        ccr_we = 1'b1;
        ccr_wd = mem_rdata[WW-1:DW] | IMASK;
      end
      ST_UNMASK: begin
        ccr_we = 1'b1;
        ccr_wd = ccr_q & ~IMASK;
        pc_we  = 1'b1;
      end
      ST_REFILL: begin
        sp_we     = 1'b1;
        sp_wd     = sp_q + FRAME_LEN;
        qfill_req = 1'b1;
      end
      ST_SVEC:  ccr_we = 1'b1;
      ST_SSP:   sp_we  = 1'b1;
      ST_SPC: begin
        pc_we = 1'b1;
        pc_wd = vec_q;
      end
      ST_SFILL: begin
        qfill_req  = 1'b1;
        qfill_addr = vec_q;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/isr_frame_seq_chk.sv
module isr_frame_seq_chk #(
  parameter int DW   = 8,
  parameter int IBIT = 4,
  localparam int WW  = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          rti_cmd,
  input logic          irq_req,
  input logic          irq_ack,
  input logic          mem_req,
  input logic          mem_we,
  input logic [WW-1:0] mem_addr,
  input logic [WW-1:0] sp_in,
  input logic          ccr_we,
  input logic [DW-1:0] ccr_wd,
  input logic          qfill_req
);

  // R5 / R9: a return command in an idle cycle starts with a read at SP
  assert_rti_first_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rti_cmd) |=> (busy && mem_req && !mem_we && mem_addr == $past(sp_in)));

  // R2: an accepted request masks first, no memory access in that cycle
  assert_entry_mask_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && irq_req && !rti_cmd) |=> (ccr_we && ccr_wd[IBIT] && !mem_req));

  // R10: memory only while busy
  assert_mem_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R10: acknowledge only while busy, never together with a memory access
  assert_ack_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (busy && !mem_req));

  // R10: refill closes the sequence
  assert_fill_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    qfill_req |=> !busy);

endmodule

bind isr_frame_seq isr_frame_seq_chk #(.DW(DW), .IBIT(IBIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .busy      (busy),
  .rti_cmd   (rti_cmd),
  .irq_req   (irq_req),
  .irq_ack   (irq_ack),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .sp_in     (sp_in),
  .ccr_we    (ccr_we),
  .ccr_wd    (ccr_wd),
  .qfill_req (qfill_req)
);

// File: tb/isr_frame_seq_test.sv
module isr_frame_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int IB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic irq_req = 1'b0, rti_cmd = 1'b0;
  logic [15:0] irq_vec = '0;
  logic irq_ack, busy;
  logic [7:0]  r_ccr, r_a, r_b;
  logic [15:0] r_x, r_y, r_pc, r_sp;
  logic ccr_we, ab_we, x_we, y_we, pc_we, sp_we;
  logic [7:0]  ccr_wd, a_wd, b_wd;
  logic [15:0] x_wd, y_wd, pc_wd, sp_wd;
  logic mem_req, mem_we, mem_wide, qfill_req;
  logic [15:0] mem_addr, mem_wdata, qfill_addr;
  logic [15:0] mem_rdata;

  // bench-side register file and stack memory
  logic ld = 1'b0;
  logic [7:0]  ld_ccr, ld_a, ld_b;
  logic [15:0] ld_x, ld_y, ld_pc, ld_sp;
  logic mw_en = 1'b0;
  logic [7:0] mw_addr, mw_data;
  logic [7:0] mem [256];

  int tests = 0, fails = 0, cycles = 0;

  isr_frame_seq uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack),
    .rti_cmd(rti_cmd), .busy(busy), .ccr_in(r_ccr), .a_in(r_a), .b_in(r_b),
    .x_in(r_x), .y_in(r_y), .pc_in(r_pc), .sp_in(r_sp),
    .ccr_we(ccr_we), .ccr_wd(ccr_wd), .ab_we(ab_we), .a_wd(a_wd), .b_wd(b_wd),
    .x_we(x_we), .x_wd(x_wd), .y_we(y_we), .y_wd(y_wd), .pc_we(pc_we), .pc_wd(pc_wd),
    .sp_we(sp_we), .sp_wd(sp_wd), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .qfill_req(qfill_req), .qfill_addr(qfill_addr)
  );

  always @(posedge clk) begin
    if (ld) begin
      r_ccr <= ld_ccr; r_a <= ld_a; r_b <= ld_b;
      r_x <= ld_x; r_y <= ld_y; r_pc <= ld_pc; r_sp <= ld_sp;
    end else begin
      if (ccr_we) r_ccr <= ccr_wd;
      if (ab_we) begin r_a <= a_wd; r_b <= b_wd; end
      if (x_we) r_x <= x_wd;
      if (y_we) r_y <= y_wd;
      if (pc_we) r_pc <= pc_wd;
      if (sp_we) r_sp <= sp_wd;
    end
    if (mw_en) mem[mw_addr] <= mw_data;
    else if (mem_req && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata[15:8];
      if (mem_wide) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[7:0];
    end
    if (mem_req && !mem_we)
      mem_rdata <= {mem[mem_addr[7:0]], mem_wide ? mem[mem_addr[7:0] + 8'd1] : 8'h00};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int i, input logic [7:0] c, a, b,
                                       input logic [15:0] x, y, ra);
    case (i)
      0: return c;
      1: return b;
      2: return a;
      3: return x[15:8];
      4: return x[7:0];
      5: return y[15:8];
      6: return y[7:0];
      7: return ra[15:8];
      default: return ra[7:0];
    endcase
  endfunction

  task automatic load_regs(input logic [7:0] c, a, b, input logic [15:0] x, y, pc, sp);
    @(negedge clk);
    ld_ccr = c; ld_a = a; ld_b = b; ld_x = x; ld_y = y; ld_pc = pc; ld_sp = sp; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  // runs one sequence; irq_req is high in busy cycles raise..drop-1 until acknowledged
  task automatic run_seq(input bit is_rti, input int raise, input int drop,
                         input logic [15:0] vec, output int nb, output int acks,
                         output int fills, output logic [15:0] qa,
                         output logic first_ok);
    bit acked = 0;
    nb = 0; acks = 0; fills = 0; qa = '0; first_ok = 1'b0;
    @(negedge clk);
    irq_vec = vec;
    rti_cmd = is_rti;
    irq_req = (!is_rti) || (raise == 0);
    @(negedge clk);
    rti_cmd = 1'b0;
    if (!is_rti) irq_req = 1'b0 || (!is_rti && 1'b1);
    while (busy && nb < 40) begin
      nb++;
      if (nb == 1) begin
        if (is_rti) first_ok = mem_req && !mem_we && !mem_wide && (mem_addr == r_sp);
        else        first_ok = ccr_we && ccr_wd[IB] && !mem_req;
      end
      if (irq_ack) begin acks++; acked = 1; end
      if (qfill_req) begin fills++; qa = qfill_addr; end
      if (is_rti) irq_req = !acked && (nb >= raise) && (nb < drop);
      else        irq_req = !acked;
      @(negedge clk);
    end
    irq_req = 1'b0;
  endtask

  task automatic do_entry(input logic [7:0] c, a, b, input logic [15:0] x, y, pc, sp, vec);
    int nb, acks, fills;
    logic [15:0] qa;
    logic fo;
    load_regs(c & ~8'h10, a, b, x, y, pc, sp);
    run_seq(1'b0, 0, 100, vec, nb, acks, fills, qa, fo);
    chk("R2 mask written first, no access", 32'(fo), 32'd1);
    chk("R4 entry busy cycles", nb, 7);
    chk("R4 entry ack count", acks, 1);
    chk("R4 entry refill addr", {fills[15:0], qa}, {16'd1, vec});
    chk("R4 entry sp", r_sp, sp - 16'd9);
    chk("R4 entry pc", r_pc, vec);
    chk("R2 mask bit after entry", 32'(r_ccr[IB]), 32'd1);
    for (int i = 0; i < 9; i++)
      chk("R3 frame byte", {i[7:0], mem[sp[7:0] - 8'd9 + i[7:0]]},
          {i[7:0], fbyte(i, c & ~8'h10, a, b, x, y, pc)});
  endtask

  task automatic do_return(input int raise, input int drop, input logic [15:0] vec);
    logic [7:0] c, a, b;
    logic [15:0] x, y, ra, sp;
    int nb, acks, fills;
    logic [15:0] qa;
    logic fo;
    bit sc;
    c = 8'($urandom); a = 8'($urandom); b = 8'($urandom);
    x = 16'($urandom); y = 16'($urandom); ra = 16'($urandom);
    sp = {8'h00, 8'h20 + 8'($urandom % 192)};
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      mw_en = 1'b1; mw_addr = sp[7:0] + i[7:0]; mw_data = fbyte(i, c, a, b, x, y, ra);
    end
    @(negedge clk);
    mw_en = 1'b0;
    load_regs(8'h10, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0, sp);
    sc = (raise <= 7) && (drop > 7);
    run_seq(1'b1, raise, drop, vec, nb, acks, fills, qa, fo);
    chk("R5/R9 first access is narrow read at sp", 32'(fo), 32'd1);
    chk("R5 restored A,B", {r_a, r_b}, {a, b});
    chk("R5 restored X,Y", {r_x, r_y}, {x, y});
    if (sc) begin
      chk("R7 busy cycles", nb, 11);
      chk("R7 ack count", acks, 1);
      chk("R7 refill at vector", {fills[15:0], qa}, {16'd1, vec});
      chk("R7 sp back to frame", r_sp, sp);
      chk("R7 pc", r_pc, vec);
      chk("R7 ccr mask set", r_ccr, c | 8'h10);
    end else begin
      chk("R6/R8 busy cycles", nb, 8);
      chk("R6/R8 no ack", acks, 0);
      chk("R6 refill at return address", {fills[15:0], qa}, {16'd1, ra});
      chk("R6 sp", r_sp, sp + 16'd9);
      chk("R6 pc", r_pc, ra);
      chk("R5 ccr mask cleared", r_ccr, c & ~8'h10);
    end
    @(negedge clk);
    chk("R8 no new sequence after return", 32'(busy), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    ld_ccr = '0; ld_a = '0; ld_b = '0; ld_x = '0; ld_y = '0; ld_pc = '0; ld_sp = 16'h0080;
    mw_addr = '0; mw_data = '0;
    ld = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ld = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 mem_req/qfill/ack", {mem_req, qfill_req, irq_ack}, 3'b000);
    chk("R1 write enables", {ccr_we, ab_we, x_we, y_we, pc_we, sp_we}, 6'b0);

    // directed corners
    do_entry(8'hC5, 8'h11, 8'h22, 16'h3344, 16'h5566, 16'h7788, 16'h0090, 16'hA0B0);
    do_return(99, 99, 16'h1234);  // R6 plain return
    do_return(7, 20, 16'h2345);   // R7 request raised exactly in decision cycle
    do_return(8, 20, 16'h3456);   // R8 request one cycle too late
    do_return(6, 7, 16'h4567);    // R8 request dropped before decision cycle
    do_return(3, 5, 16'h5678);    // R8 request early in restore
    do_return(0, 20, 16'h6789);   // R9 command and request in the same idle cycle

    // random mix
    for (int k = 0; k < 30; k++) begin
      int rz;
      rz = int'($urandom % 12);
      do_entry(8'($urandom), 8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom),
               16'($urandom), {8'h00, 8'h20 + 8'($urandom % 192)}, 16'($urandom));
      do_return(rz, rz + 1 + int'($urandom % 10), 16'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule